// File: doc/BRIEF.md
# Sixteen-line GPIO command port

This block gives a host byte stream control of sixteen general-purpose lines. Lines 0 to 5 can drive or listen; lines 6 to 15 only listen. The host changes the drive state by opening a stream packet with one opcode byte. Inside the packet, tagged sub-opcode bytes load the direction mask or the output values of the six drivable lines. A closing byte ends the packet. The drive state goes straight to the pad enable and pad data outputs.

A separate single-byte command asks for a status reply. The block takes one coherent snapshot of every line level, plus the levels of the serial-bus clock and data pins. It writes the snapshot as a six-byte frame into a byte-wide response FIFO, which the host drains one byte at a time. Every external level passes through a two-flop synchroniser before it can reach a reply.

Top module: `gpio_cmd_port`

## Requirements
- R1: After reset, all `pad_oe` and `pad_out` bits are 0, so every line is an input, and `rsp_valid` is 0.
- R2: Byte 0xAB, received while no packet is open, opens a stream packet, and byte 0x20 inside a packet closes it. Outside a packet, every byte other than 0xAB and 0xA0 has no effect.
- R3: Inside a packet, a byte with bits [7:6] = 01 loads its bits [5:0] as the direction of lines 0 to 5. In this mask, 1 means output and 0 means input. The new value appears on `pad_oe[5:0]` after the clock edge that accepts the byte.
- R4: Inside a packet, a byte with bits [7:6] = 10 loads its bits [5:0] as the output values of lines 0 to 5. `pad_out[i]` equals value[i] AND direction[i], so a line whose direction bit is 0 shows 0.
- R5: `pad_oe[15:6]` and `pad_out[15:6]` stay 0 under every command sequence.
- R6: Byte 0xA0, received while no packet is open, adds a six-byte frame to the response FIFO, read out in this order:
  - byte 0 holds lines 7..0, with bit i = line i;
  - byte 1 holds lines 15..8, with bit i = line 8+i;
  - byte 2 holds the four bus-pin levels in bits 3..0, with upper bits 0;
  - bytes 3 to 5 are 0.
- R7: A status command accepted at clock edge E reports the `pad_in` and `bus_pin_in` levels sampled at edge E-2, which is the two-flop synchroniser delay.
- R8: All six bytes of a frame come from one snapshot. Input changes after the accepting edge do not alter bytes of that frame that are still queued.
- R9: A status command is dropped when the FIFO has fewer than six free bytes (depth 16). Frames are read out in the order they were accepted, and `rsp_valid` falls once the FIFO is empty.
- R10: Inside a packet, byte 0xA0 is an output-value load (value 0x20) and produces no reply. A byte with bits [7:6] = 11 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command byte from host |
| pad_in | input | 16 | Raw pad levels of lines 0 to 15 |
| bus_pin_in | input | 4 | Raw levels of serial-bus clock/data pins |
| rsp_pop | input | 1 | Consume the head reply byte |
| pad_oe | output | 16 | Pad output enable per line |
| pad_out | output | 16 | Pad drive value per line |
| rsp_valid | output | 1 | Reply FIFO not empty |
| rsp_byte | output | 8 | Head reply byte |

## Verification
The hardest cases to reach from the ports involve timing. One is a line change that lands inside the two-flop window just before a status command; the bench changes `pad_in` one cycle before a command and again between back-to-back commands, then checks that the first reply shows the old level and the second shows the new one. The other is a status request that finds the FIFO nearly full. To reach it, the bench sends three requests without popping and loads different pin patterns for each, so the dropped third frame is unmistakable when the queue is drained.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 6;

    localparam logic [7:0] OP_STREAM = 8'hAB;
    localparam logic [7:0] OP_STATUS = 8'hA0;
    localparam logic [7:0] SUB_CLOSE = 8'h20;
    localparam logic [1:0] TAG_DIR   = 2'b01;
    localparam logic [1:0] TAG_VAL   = 2'b10;

    typedef enum logic {PS_IDLE, PS_STREAM} pkt_state_e;

    typedef logic [FRAME_BYTES-1:0][BYTE_W-1:0] frame_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [1:0]   warm;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        if (st_q.warm != 2'd2) st_d.warm = st_q.warm + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_cmd_parser.sv
module gpio_cmd_parser
    import gpio_port_pkg::*;
#(
    parameter int NUM_BIDIR = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_byte,
    output logic [NUM_BIDIR-1:0] dir,
    output logic [NUM_BIDIR-1:0] val,
    output logic                 status_req
);
    typedef struct packed {
        pkt_state_e           mode;
        logic [NUM_BIDIR-1:0] dir;
        logic [NUM_BIDIR-1:0] val;
    } parse_t;

    parse_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        status_req = 1'b0;
        if (cmd_valid) begin
            if (st_q.mode == PS_IDLE) begin
                if (cmd_byte == OP_STREAM)      st_d.mode  = PS_STREAM;
                else if (cmd_byte == OP_STATUS) status_req = 1'b1;
            end else begin
                if (cmd_byte == SUB_CLOSE)          st_d.mode = PS_IDLE;
                else if (cmd_byte[7:6] == TAG_DIR)  st_d.dir  = cmd_byte[NUM_BIDIR-1:0];
                else if (cmd_byte[7:6] == TAG_VAL)  st_d.val  = cmd_byte[NUM_BIDIR-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: PS_IDLE, dir: '0, val: '0};
        else        st_q <= st_d;
    end

    assign dir = st_q.dir;
    assign val = st_q.val;

    // R3
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir != $past(dir)) |-> $past(cmd_valid && st_q.mode == PS_STREAM && cmd_byte[7:6] == TAG_DIR));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PS_IDLE) |=> ($stable(dir) && $stable(val)));
endmodule

// File: rtl/gpio_rsp_fifo.sv
module gpio_rsp_fifo
    import gpio_port_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_req,
    input  frame_t     frame,
    input  logic       pop,
    output logic       valid,
    output logic [7:0] head
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [7:0] mem [DEPTH];
    logic       push_ok, pop_ok;
    logic [CW-1:0] free_slots;

    assign free_slots = CW'(DEPTH) - st_q.cnt;
    assign push_ok    = push_req && (free_slots >= CW'(FRAME_BYTES));
    assign pop_ok     = pop && (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wr  = st_q.wr + AW'(FRAME_BYTES);
            st_d.cnt = st_d.cnt + CW'(FRAME_BYTES);
        end
        if (pop_ok) begin
            st_d.rd  = st_q.rd + AW'(1);
            st_d.cnt = st_d.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            for (int k = 0; k < FRAME_BYTES; k++) begin
                mem[AW'(st_q.wr + AW'(k))] <= frame[k];
            end
        end
    end

    assign valid = (st_q.cnt != '0);
    assign head  = mem[st_q.rd];

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R9
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && (free_slots < CW'(FRAME_BYTES)) && !pop) |=> $stable(st_q.cnt));

    // R6
    frame_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop) |=> (st_q.cnt == $past(st_q.cnt) + CW'(FRAME_BYTES)));
endmodule

// File: rtl/gpio_cmd_port.sv
module gpio_cmd_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int NUM_BIDIR  = 6,
    parameter int BUS_PINS   = 4,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_byte,
    input  logic [NUM_LINES-1:0] pad_in,
    input  logic [BUS_PINS-1:0]  bus_pin_in,
    input  logic                 rsp_pop,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] pad_out,
    output logic                 rsp_valid,
    output logic [7:0]           rsp_byte
);
    localparam int SYNC_W = NUM_LINES + BUS_PINS;

    logic [SYNC_W-1:0]    synced;
    logic [NUM_BIDIR-1:0] dir, val;
    logic                 status_req;
    logic [15:0]          lines16;
    frame_t               frame;

    gpio_in_sync #(.W(SYNC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_pin_in, pad_in}),
        .dout (synced)
    );

    gpio_cmd_parser #(.NUM_BIDIR(NUM_BIDIR)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .dir       (dir),
        .val       (val),
        .status_req(status_req)
    );

    assign lines16 = 16'(synced[NUM_LINES-1:0]);

    always_comb begin
        frame    = '0;
        frame[0] = lines16[7:0];
        frame[1] = lines16[15:8];
        frame[2] = 8'(synced[SYNC_W-1:NUM_LINES]);
    end

    gpio_rsp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_req(status_req),
        .frame   (frame),
        .pop     (rsp_pop),
        .valid   (rsp_valid),
        .head    (rsp_byte)
    );

    assign pad_oe  = NUM_LINES'(dir);
    assign pad_out = NUM_LINES'(val & dir);

    // R4
    drive_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_out[0]) |-> pad_oe[0]);
endmodule

// File: tb/gpio_cmd_port_tb.sv
module gpio_cmd_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [15:0] pad_in = 16'h0000;
    logic [3:0]  bus_pin_in = 4'h0;
    logic        rsp_pop = 1'b0;
    logic [15:0] pad_oe, pad_out;
    logic        rsp_valid;
    logic [7:0]  rsp_byte;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    gpio_cmd_port u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .pad_in(pad_in), .bus_pin_in(bus_pin_in), .rsp_pop(rsp_pop),
        .pad_oe(pad_oe), .pad_out(pad_out), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Called at a negedge; returns at the next negedge.
    task automatic send(input logic [7:0] b);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input int k, input logic [15:0] p, input logic [3:0] b);
        case (k)
            0: return p[7:0];
            1: return p[15:8];
            2: return {4'h0, b};
            default: return 8'h00;
        endcase
    endfunction

    task automatic pop_frame(input string req, input logic [15:0] p, input logic [3:0] b);
        for (int k = 0; k < 6; k++) begin
            check(req, {31'd0, rsp_valid}, 32'd1);
            check(req, {24'd0, rsp_byte}, {24'd0, exp_byte(k, p, b)});
            rsp_pop = 1'b1;
            @(negedge clk);
            rsp_pop = 1'b0;
        end
    endtask

    initial begin
        logic [5:0] v;
        logic [15:0] pa, pb;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {16'd0, pad_oe}, 32'd0);
        check("R1", {16'd0, pad_out}, 32'd0);
        check("R1", {31'd0, rsp_valid}, 32'd0);

        // R2 sub-opcodes outside a packet are ignored
        send(8'h7F);
        send(8'hBF);
        send(8'h55);
        check("R2", {16'd0, pad_oe}, 32'd0);
        check("R2", {16'd0, pad_out}, 32'd0);
        check("R2", {31'd0, rsp_valid}, 32'd0);

        // R3 R4 R5 sweep over every direction mask
        send(8'hAB);
        for (int d = 0; d < 64; d++) begin
            send(8'h40 | 8'(d));
            check("R3", {16'd0, pad_oe}, 32'(d));
            for (int j = 0; j < 4; j++) begin
                case (j)
                    0: v = 6'h00;
                    1: v = 6'h3F;
                    2: v = 6'(d) ^ 6'h15;
                    default: v = ~6'(d);
                endcase
                send(8'h80 | {2'b00, v});
                check("R4", {16'd0, pad_out}, {26'd0, v & 6'(d)});
                check("R5", {22'd0, pad_oe[15:6]}, 32'd0);
                check("R5", {22'd0, pad_out[15:6]}, 32'd0);
            end
        end
        // R10 ignored tag and 0xA0 inside a packet
        send(8'hBF);
        send(8'hC5);
        check("R10", {16'd0, pad_oe}, 32'h3F);
        check("R10", {16'd0, pad_out}, 32'h3F);
        send(8'hA0);
        check("R10", {16'd0, pad_out}, 32'h20);
        check("R10", {31'd0, rsp_valid}, 32'd0);
        // R2 close, then loads ignored
        send(8'h20);
        send(8'h45);
        send(8'h81);
        check("R2", {16'd0, pad_oe}, 32'h3F);
        check("R2", {16'd0, pad_out}, 32'h20);
        send(8'hAB);
        send(8'h40);
        send(8'h20);
        check("R3", {16'd0, pad_oe}, 32'd0);

        // R6 status frame sweep
        for (int i = 0; i < 24; i++) begin
            pa = (i < 16) ? (16'h1 << i) : (16'hA5C3 ^ 16'(i * 16'h1111));
            pad_in = pa;
            bus_pin_in = 4'(i);
            idle(2);
            send(8'hA0);
            pop_frame("R6", pa, 4'(i));
            check("R6", {31'd0, rsp_valid}, 32'd0);
        end

        // R7 synchroniser delay, R8 coherence
        pa = 16'h1234; pb = 16'hFEDC;
        pad_in = pa; bus_pin_in = 4'h5;
        idle(3);
        pad_in = pb; bus_pin_in = 4'hA;
        idle(1);
        send(8'hA0);
        send(8'hA0);
        pad_in = 16'h0F0F; bus_pin_in = 4'h3;
        pop_frame("R7", pa, 4'h5);
        pop_frame("R8", pb, 4'hA);

        // R9 drop when full, order preserved
        pad_in = 16'h1111; bus_pin_in = 4'h1; idle(2); send(8'hA0);
        pad_in = 16'h2222; bus_pin_in = 4'h2; idle(2); send(8'hA0);
        pad_in = 16'h3333; bus_pin_in = 4'h3; idle(2); send(8'hA0);
        pop_frame("R9", 16'h1111, 4'h1);
        pop_frame("R9", 16'h2222, 4'h2);
        check("R9", {31'd0, rsp_valid}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule